// File: doc/BRIEF.md
# Serial Audio Link Frame Controller

This block is the controller end of a codec serial audio link. It runs entirely on the bit clock that the codec supplies. It counts that clock into fixed 256-bit frames and drives the frame sync strobe. In every frame it sends one serial output word and receives one serial input word.

A frame opens with a 16-bit tag slot, followed by twelve 20-bit data slots. All fields are sent MSB first. The codec sets the effective sample rate, never the controller. The incoming tag slot marks which capture slots carry real samples, and only those are handed to the capture streams. Request bits in incoming slot 1 name the playback slots the codec wants in the next frame. The controller offers each playback stream a single acceptance cycle per frame, and only for channels that were requested. A request that finds no sample waiting is sent as an empty slot and raised as an underrun.

Channel `c` (0-based) uses data slot `3 + c` in both directions. Playback and capture samples move over per-channel valid/ready streams.

Top module: `ac97_link_ctrl`

## Requirements
- R1: Frame sync is high for 16 consecutive bit clocks in every 256-clock frame. It rises one bit clock before output frame bit 0, and the first active edge after reset already raises it.
- R2: Output frame bit 0 (tag bit 15) is 1 when at least one playback slot in the frame carries data. Output frame bit `s` (tag bit 15-s) is 1 exactly when data slot `s` carries a sample. Every other tag bit is 0.
- R3: Output data slot `3+c` occupies frame bits `16+20*(2+c)` to `16+20*(2+c)+19` and carries the accepted sample MSB first. It is all zero when no sample was accepted. All other data slots are zero.
- R4: Incoming slot 1 word bit `14-s` = 1 (active high) requests playback slot `s`. For each channel requested in the current incoming frame, `pb_ready` is high for one cycle, at frame position 254. A sample is taken when `pb_valid` is also high in that cycle, and it is sent in the next frame.
- R5: A requested channel whose `pb_valid` is low in its ready cycle gets a zero slot with its tag bit clear, and `pb_underrun` pulses for one cycle at position 255.
- R6: Incoming tag bit `15-s` = 1 marks capture slot `s` valid. An unmarked capture slot changes nothing on the capture stream, whatever data it holds.
- R7: Input bits are sampled on the falling bit-clock edge. A valid capture sample appears on `cap_data` with `cap_valid` high one rising edge after its last bit (position 76 for channel 0, 96 for channel 1). It is held until `cap_ready` is high at a rising edge.
- R8: A valid capture sample that arrives while the previous one is still held and `cap_ready` is low is dropped. The held sample is kept, and `cap_overrun` pulses for one cycle.
- R9: A synchronous active-high reset clears the frame position, pending requests, held capture samples and accepted playback samples. During reset, sync, serial output, `pb_ready` and `cap_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock supplied by the codec |
| rst | input | 1 | Synchronous active-high reset |
| link_sync | output | 1 | Frame sync strobe |
| link_sdo | output | 1 | Serial data to the codec |
| link_sdi | input | 1 | Serial data from the codec |
| pb_valid | input | NCH | Playback sample available, per channel |
| pb_ready | output | NCH | Playback sample taken this cycle, per channel |
| pb_data | input | NCH*SW | Playback samples, channel 0 in the low bits |
| pb_underrun | output | NCH | Requested playback sample was missing |
| cap_valid | output | NCH | Capture sample held, per channel |
| cap_ready | input | NCH | Capture consumer accepts the sample |
| cap_data | output | NCH*SW | Capture samples, channel 0 in the low bits |
| cap_overrun | output | NCH | Capture sample dropped |

## Verification
The bench attacks the timing of a request-and-commit pair. If the design applied a request to the same frame, or kept a stale one, samples would show up a frame early or late and the tag bits would disagree with the slot data. Frames with tags cleared but busy data slots expose a design that ignores the tag and pushes garbage to capture. Runs with a held sample and `cap_ready` low catch a design that overwrites instead of dropping. Unfilled requests catch one that resends an old sample instead of zero. A reset between two busy frames shows whether accepted samples survive reset.

// File: rtl/ac97_link_pkg.sv
package ac97_link_pkg;
  localparam int TAG_BITS    = 16;
  localparam int SAMPLE_BITS = 20;
  localparam int DATA_SLOTS  = 12;
  localparam int FRAME_BITS  = TAG_BITS + DATA_SLOTS * SAMPLE_BITS;
  localparam int CNT_W       = $clog2(FRAME_BITS);
  localparam int SLOT_W      = $clog2(DATA_SLOTS + 1);
  localparam int SBIT_W      = $clog2(SAMPLE_BITS);
  localparam int FIRST_PCM   = 3;
  localparam int REQ_BIT_FIRST = 14 - FIRST_PCM;

  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0]  CNT_READY = CNT_W'(FRAME_BITS - 2);
  localparam logic [CNT_W-1:0]  SYNC_LAST = CNT_W'(TAG_BITS - 1);
  localparam logic [SLOT_W-1:0] SLOT_TAG  = '0;
  localparam logic [SLOT_W-1:0] SLOT_REQ  = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(DATA_SLOTS);
  localparam logic [SBIT_W-1:0] TAG_END   = SBIT_W'(TAG_BITS - 1);
  localparam logic [SBIT_W-1:0] DATA_END  = SBIT_W'(SAMPLE_BITS - 1);

  typedef struct packed {
    logic [CNT_W-1:0]  cnt;
    logic [SLOT_W-1:0] slot;
    logic [SBIT_W-1:0] sbit;
  } frame_pos_t;

  function automatic logic [SBIT_W-1:0] slot_end_bit(input logic [SLOT_W-1:0] s);
    return (s == SLOT_TAG) ? TAG_END : DATA_END;
  endfunction
endpackage

// File: rtl/ac97_frame_timer.sv
module ac97_frame_timer
  import ac97_link_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  output frame_pos_t pos,
  output logic       sync_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pos.cnt  <= CNT_LAST;
      pos.slot <= SLOT_LAST;
      pos.sbit <= DATA_END;
      sync_q   <= 1'b0;
    end else begin
      sync_q  <= (pos.cnt == CNT_LAST) || (pos.cnt < SYNC_LAST);
      pos.cnt <= (pos.cnt == CNT_LAST) ? '0 : pos.cnt + 1'b1;
      if (pos.sbit == slot_end_bit(pos.slot)) begin
        pos.sbit <= '0;
        pos.slot <= (pos.slot == SLOT_LAST) ? SLOT_TAG : pos.slot + 1'b1;
      end else begin
        pos.sbit <= pos.sbit + 1'b1;
      end
    end
  end

  // R1: sync only rises as a new frame count starts
  a_r1_sync_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_q) |-> pos.cnt == '0);
  // R1: sync never reaches past the tag slot
  a_r1_sync_window: assert property (@(posedge clk) disable iff (rst)
    sync_q |-> pos.cnt <= SYNC_LAST);
endmodule

// File: rtl/ac97_tx_path.sv
module ac97_tx_path
  import ac97_link_pkg::*;
#(
  parameter int NCH = 2,
  parameter int SW  = SAMPLE_BITS
) (
  input  logic            clk,
  input  logic            rst,
  input  frame_pos_t      pos,
  input  logic [NCH-1:0]  req_pend,
  input  logic [NCH-1:0]  pb_valid,
  input  logic [NCH*SW-1:0] pb_data,
  output logic [NCH-1:0]  pb_ready_q,
  output logic [NCH-1:0]  underrun_q,
  output logic            sdo_q
);
  logic [NCH-1:0] tx_vld;
  logic [SW-1:0]  tx_data [NCH];
  logic           bit_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      pb_ready_q <= '0;
      underrun_q <= '0;
      tx_vld     <= '0;
      for (int ch = 0; ch < NCH; ch++) tx_data[ch] <= '0;
    end else begin
      for (int ch = 0; ch < NCH; ch++) begin
        pb_ready_q[ch] <= (pos.cnt == CNT_READY) && req_pend[ch];
        underrun_q[ch] <= 1'b0;
        if (pos.cnt == CNT_LAST) begin
          if (pb_ready_q[ch] && pb_valid[ch]) begin
            tx_vld[ch]  <= 1'b1;
            tx_data[ch] <= pb_data[ch*SW +: SW];
          end else begin
            tx_vld[ch]     <= 1'b0;
            tx_data[ch]    <= '0;
            underrun_q[ch] <= pb_ready_q[ch];
          end
        end
      end
    end
  end

  always_comb begin
    bit_next = 1'b0;
    if (pos.slot == SLOT_TAG) begin
      if (pos.sbit == '0) bit_next = |tx_vld;
      for (int ch = 0; ch < NCH; ch++)
        if (pos.sbit == SBIT_W'(FIRST_PCM + ch)) bit_next = tx_vld[ch];
    end else begin
      for (int ch = 0; ch < NCH; ch++)
        if (pos.slot == SLOT_W'(FIRST_PCM + ch) && tx_vld[ch])
          bit_next = tx_data[ch][SBIT_W'(SW - 1) - pos.sbit];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sdo_q <= 1'b0;
    else     sdo_q <= bit_next;
  end

  // R2: frame-valid bit on the wire matches the committed slot set
  a_r2_frame_valid: assert property (@(posedge clk) disable iff (rst)
    (pos.cnt == CNT_W'(1)) |-> (sdo_q == |tx_vld));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R4: acceptance window is one cycle at the frame tail
    a_r4_ready_pulse: assert property (@(posedge clk) disable iff (rst)
      pb_ready_q[g] |-> (pos.cnt == CNT_LAST) ##1 !pb_ready_q[g]);
    // R5: underrun only after an unfilled acceptance window
    a_r5_underrun_cause: assert property (@(posedge clk) disable iff (rst)
      underrun_q[g] |-> ($past(pb_ready_q[g]) && !$past(pb_valid[g]) && !tx_vld[g]));
  end
endmodule

// File: rtl/ac97_rx_path.sv
module ac97_rx_path
  import ac97_link_pkg::*;
#(
  parameter int NCH = 2,
  parameter int SW  = SAMPLE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  frame_pos_t        pos,
  input  logic              sdi,
  input  logic [NCH-1:0]    cap_ready,
  output logic [NCH-1:0]    cap_valid_q,
  output logic [NCH*SW-1:0] cap_data_q,
  output logic [NCH-1:0]    overrun_q,
  output logic [NCH-1:0]    req_pend
);
  logic              sdi_n;
  logic              rx_live;
  logic [SLOT_W-1:0] rx_slot;
  logic [SBIT_W-1:0] rx_sbit;
  logic [SW-1:0]     sr;
  logic [SW-1:0]     word;
  logic [NCH-1:0]    cap_tag;
  logic              slot_done;

  always_ff @(negedge clk) sdi_n <= sdi;

  assign word      = {sr[SW-2:0], sdi_n};
  assign slot_done = rx_live && (rx_sbit == slot_end_bit(rx_slot));

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_live     <= 1'b0;
      rx_slot     <= SLOT_TAG;
      rx_sbit     <= '0;
      sr          <= '0;
      cap_tag     <= '0;
      req_pend    <= '0;
      cap_valid_q <= '0;
      cap_data_q  <= '0;
      overrun_q   <= '0;
    end else begin
      rx_live <= 1'b1;
      rx_slot <= pos.slot;
      rx_sbit <= pos.sbit;
      if (rx_live) sr <= word;
      for (int ch = 0; ch < NCH; ch++) begin
        logic hit;
        if (slot_done && rx_slot == SLOT_TAG)
          cap_tag[ch] <= word[TAG_BITS - 1 - FIRST_PCM - ch];
        if (slot_done && rx_slot == SLOT_REQ)
          req_pend[ch] <= word[REQ_BIT_FIRST - ch];
        hit = slot_done && (rx_slot == SLOT_W'(FIRST_PCM + ch)) && cap_tag[ch];
        overrun_q[ch] <= hit && cap_valid_q[ch] && !cap_ready[ch];
        if (hit && (!cap_valid_q[ch] || cap_ready[ch])) begin
          cap_valid_q[ch]          <= 1'b1;
          cap_data_q[ch*SW +: SW]  <= word;
        end else if (cap_valid_q[ch] && cap_ready[ch]) begin
          cap_valid_q[ch] <= 1'b0;
        end
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R7: a held sample stays put until taken
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
      (cap_valid_q[g] && !cap_ready[g]) |=> (cap_valid_q[g] && $stable(cap_data_q[g*SW +: SW])));
    // R8: an overrun leaves the older sample in place
    a_r8_overrun_held: assert property (@(posedge clk) disable iff (rst)
      overrun_q[g] |-> cap_valid_q[g]);
    // R6: a new sample only appears when its tag marked it
    a_r6_tagged_only: assert property (@(posedge clk) disable iff (rst)
      $rose(cap_valid_q[g]) |-> $past(cap_tag[g]));
  end
endmodule

// File: rtl/ac97_link_ctrl.sv
module ac97_link_ctrl
  import ac97_link_pkg::*;
#(
  parameter int NCH = 2,
  parameter int SW  = SAMPLE_BITS
) (
  input  logic              bit_clk,
  input  logic              rst,
  output logic              link_sync,
  output logic              link_sdo,
  input  logic              link_sdi,
  input  logic [NCH-1:0]    pb_valid,
  output logic [NCH-1:0]    pb_ready,
  input  logic [NCH*SW-1:0] pb_data,
  output logic [NCH-1:0]    pb_underrun,
  output logic [NCH-1:0]    cap_valid,
  input  logic [NCH-1:0]    cap_ready,
  output logic [NCH*SW-1:0] cap_data,
  output logic [NCH-1:0]    cap_overrun
);
  frame_pos_t     pos;
  logic [NCH-1:0] req_pend;

  ac97_frame_timer u_timer (
    .clk    (bit_clk),
    .rst    (rst),
    .pos    (pos),
    .sync_q (link_sync)
  );

  ac97_tx_path #(.NCH(NCH), .SW(SW)) u_tx (
    .clk        (bit_clk),
    .rst        (rst),
    .pos        (pos),
    .req_pend   (req_pend),
    .pb_valid   (pb_valid),
    .pb_data    (pb_data),
    .pb_ready_q (pb_ready),
    .underrun_q (pb_underrun),
    .sdo_q      (link_sdo)
  );

  ac97_rx_path #(.NCH(NCH), .SW(SW)) u_rx (
    .clk         (bit_clk),
    .rst         (rst),
    .pos         (pos),
    .sdi         (link_sdi),
    .cap_ready   (cap_ready),
    .cap_valid_q (cap_valid),
    .cap_data_q  (cap_data),
    .overrun_q   (cap_overrun),
    .req_pend    (req_pend)
  );
endmodule

// File: tb/ac97_link_ctrl_bench.sv
module ac97_link_ctrl_bench;
  localparam int NCH = 2;
  localparam int SW  = 20;
  localparam int FB  = 256;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              link_sync, link_sdo;
  logic              link_sdi = 1'b0;
  logic [NCH-1:0]    pb_valid = '0, pb_ready, pb_underrun;
  logic [NCH*SW-1:0] pb_data = '0;
  logic [NCH-1:0]    cap_valid, cap_overrun;
  logic [NCH-1:0]    cap_ready = '0;
  logic [NCH*SW-1:0] cap_data;

  always #5 clk = ~clk;

  ac97_link_ctrl #(.NCH(NCH), .SW(SW)) u_ac97_link_ctrl (
    .bit_clk(clk), .rst(rst), .link_sync(link_sync), .link_sdo(link_sdo),
    .link_sdi(link_sdi), .pb_valid(pb_valid), .pb_ready(pb_ready),
    .pb_data(pb_data), .pb_underrun(pb_underrun), .cap_valid(cap_valid),
    .cap_ready(cap_ready), .cap_data(cap_data), .cap_overrun(cap_overrun));

  int n_cmp = 0;
  int n_bad = 0;

  logic [FB-1:0]  ef;
  logic [NCH-1:0] exp_cv, rdy_prev;
  logic [SW-1:0]  exp_cd [NCH];
  logic [SW-1:0]  pb_next [NCH];

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [FB-1:0] put_word(input logic [FB-1:0] f, input int s, input logic [SW-1:0] w);
    for (int j = 0; j < SW; j++) f[16 + 20*(s-1) + j] = w[SW-1-j];
    return f;
  endfunction

  function automatic logic [FB-1:0] codec_frame(input logic [NCH-1:0] tagv,
      input logic [NCH-1:0] req, input logic [NCH*SW-1:0] d);
    logic [FB-1:0] f = '0;
    logic [15:0] tw = 16'h8000;
    logic [SW-1:0] rw = 20'h00000;
    for (int c = 0; c < NCH; c++) begin
      tw[12-c] = tagv[c];
      rw[11-c] = req[c];
    end
    for (int k = 0; k < 16; k++) f[k] = tw[15-k];
    for (int s = 1; s <= 12; s++) f = put_word(f, s, 20'hA5A5A ^ SW'(s * 77));
    f = put_word(f, 1, rw);
    for (int c = 0; c < NCH; c++) f = put_word(f, 3 + c, d[c*SW +: SW]);
    return f;
  endfunction

  function automatic logic [FB-1:0] ctrl_frame(input logic [NCH-1:0] vld, input logic [NCH*SW-1:0] d);
    logic [FB-1:0] f = '0;
    f[0] = |vld;
    for (int c = 0; c < NCH; c++) begin
      f[3+c] = vld[c];
      if (vld[c]) f = put_word(f, 3 + c, d[c*SW +: SW]);
    end
    return f;
  endfunction

  task automatic do_reset();
    rst = 1'b1; link_sdi = 1'b0; pb_valid = '0; cap_ready = '0;
    repeat (4) @(posedge clk);
    #2;
    chk("R9 sync in reset", 32'(link_sync), 0);
    chk("R9 sdo in reset", 32'(link_sdo), 0);
    chk("R9 pb_ready in reset", 32'(pb_ready), 0);
    chk("R9 cap_valid in reset", 32'(cap_valid), 0);
    @(posedge clk); #1; rst = 1'b0;
    exp_cv = '0; rdy_prev = '0; ef = '0;
    @(posedge clk); #2;
    chk("R1 sync precursor", 32'(link_sync), 1);
    chk("R9 sdo after reset", 32'(link_sdo), 0);
  endtask

  task automatic run_frame(input logic [NCH-1:0] tagv, input logic [NCH-1:0] req,
      input logic [NCH-1:0] rdy, input logic [NCH-1:0] pbv, input logic [NCH*SW-1:0] capd);
    logic [FB-1:0] cf = codec_frame(tagv, req, capd);
    logic [NCH*SW-1:0] sent;
    logic [NCH-1:0] exp_ovr;
    for (int p = 0; p < FB; p++) begin
      @(posedge clk); #1;
      link_sdi = cf[p];
      if (p == 0) begin
        pb_valid  = pbv;
        cap_ready = rdy;
        for (int c = 0; c < NCH; c++) pb_data[c*SW +: SW] = pb_next[c];
      end
      for (int c = 0; c < NCH; c++) begin
        exp_ovr[c] = 1'b0;
        if (p == 76 + 20*c && tagv[c]) begin
          if (!exp_cv[c] || rdy_prev[c]) begin
            exp_cv[c] = 1'b1;
            exp_cd[c] = capd[c*SW +: SW];
          end else exp_ovr[c] = 1'b1;
        end else if (exp_cv[c] && rdy_prev[c]) exp_cv[c] = 1'b0;
      end
      #1;
      chk("R1 sync", 32'(link_sync), 32'((p < 15) || (p == 255)));
      if (p < 16) chk("R2 tag bit", 32'(link_sdo), 32'(ef[p]));
      else        chk("R3 slot data bit", 32'(link_sdo), 32'(ef[p]));
      chk("R4 pb_ready", 32'(pb_ready), (p == 254) ? 32'(req) : 0);
      chk("R5 pb_underrun", 32'(pb_underrun), (p == 255) ? 32'(req & ~pbv) : 0);
      chk("R6 cap_valid", 32'(cap_valid), 32'(exp_cv));
      for (int c = 0; c < NCH; c++)
        if (exp_cv[c]) chk("R7 cap_data", 32'(cap_data[c*SW +: SW]), 32'(exp_cd[c]));
      chk("R8 cap_overrun", 32'(cap_overrun), 32'(exp_ovr));
      rdy_prev = cap_ready;
      if (p == 255) begin
        for (int c = 0; c < NCH; c++) sent[c*SW +: SW] = pb_next[c];
        ef = ctrl_frame(req & pbv, sent);
        for (int c = 0; c < NCH; c++)
          if (req[c] && pbv[c]) pb_next[c] = SW'($urandom);
      end
    end
  endtask

  function automatic logic [NCH*SW-1:0] rnd_caps();
    return {SW'($urandom), SW'($urandom)};
  endfunction

  initial begin
    void'($urandom(32'h5EED_0A97));
    for (int c = 0; c < NCH; c++) pb_next[c] = SW'($urandom);
    do_reset();
    run_frame(2'b11, 2'b11, 2'b11, 2'b11, rnd_caps());  // R4 R3 basic exchange
    run_frame(2'b00, 2'b11, 2'b11, 2'b00, rnd_caps());  // R5 underrun, R6 untagged data
    run_frame(2'b11, 2'b01, 2'b00, 2'b01, rnd_caps());  // R7 held capture
    run_frame(2'b11, 2'b10, 2'b00, 2'b11, rnd_caps());  // R8 overrun on both
    run_frame(2'b10, 2'b00, 2'b11, 2'b11, rnd_caps());  // drain, no requests
    for (int f = 0; f < 36; f++)
      run_frame(2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom), rnd_caps());
    run_frame(2'b11, 2'b11, 2'b00, 2'b11, rnd_caps());
    do_reset();                                          // R9 clears held state
    run_frame(2'b00, 2'b00, 2'b11, 2'b00, rnd_caps());
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(10 * 190000);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule